// File: doc/BRIEF.md
# Power-Controller Register Target on a Two-Wire Serial Bus

This block is the control port of a supply-controller chip. It sits on a standard I2C bus as a target and holds four 8-bit system registers. The block oversamples SCL and SDA with a fast system clock and removes short spikes from both lines. It finds START and STOP conditions and answers one of four 7-bit addresses, chosen by two pins. It pulls SDA low through an open-drain enable. Clock stretching is not supported.

A write carries no sub-address byte. Instead, the top three bits of every data byte name the target register, and the low five bits carry that register's fields. Any number of data bytes may follow one address. A read returns the four registers one after the other, starting at the first register. In the returned data, the read-only positions hold live fault and tone flags taken from inputs.

A power-good input gates the whole interface. While power-good is low, the block clears every register, which turns the output enable off, and it does not answer the bus.

Top module: `pwr_i2c_target`

## Requirements
- R1: The target address is 0b00010 followed by `addr_sel[1]` and `addr_sel[0]`, so it ranges from 0x08 to 0x0B. On a match, the block pulls SDA low during the ninth clock. Any other address gets no acknowledge, and the rest of that transfer is ignored.
- R2: Bits 7:5 of each written data byte select the register: 000 = status, 001 = control A, 010 = control B, 011 = output register. Every data byte after a matched write address is acknowledged, and each byte of a multi-byte write takes effect.
- R3: A write to control A loads bits 4:0 into `ctrl_a`, and a write to control B loads bits 4:0 into `ctrl_b`. A write to the output register loads bit 4 into `out_enable` and bits 1:0 into `volt_sel` (bit 1 = upper range, bit 0 = fine step). All fields of one byte change in the same clock cycle, so `out_enable` never rises before the other fields.
- R4: The following writes change no output: writes to the status register, writes to bits 3:2 of the output register, and writes with selector codes 100 to 111.
- R5: A read byte is sent MSB first and has one of these formats:
  - status register: {000, fault_in[4:0]}, where fault_in[4] = over-temperature, [3] = cable fault, [2] = over/under-voltage, [1] = overload, [0] = backward current;
  - control A: {001, ctrl_a};
  - control B: {010, ctrl_b};
  - output register: {011, out_enable, tone_det, 0, volt_sel}.
- R6: Within one read, bytes come in the order status, control A, control B, output register, then wrap back to status. Every START sets the order back to the status register.
- R7: When the master acknowledges a read byte, the next byte follows. When the master does not acknowledge, the block releases SDA and stays idle until the next START.
- R8: A STOP in any state ends the transfer and leaves the registers as they were. A START in any state begins a new address phase, and a partial data byte is discarded.
- R9: While `pwr_good` is low, all register outputs are 0, `sda_pull` is 0, and bus traffic gets no acknowledge.
- R10: A pulse of 50 ns or less on SCL or SDA changes nothing. A spike on SDA while SCL is high does not count as START or STOP, and a spike on SCL does not count as a clock.
- R11: After reset, all register outputs and `sda_pull` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply-good level, synchronous to clk |
| addr_sel | input | 2 | Low two bits of the target address |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| fault_in | input | 5 | Live fault flags, merged into status reads |
| tone_det | input | 1 | Live tone-detect flag, merged into output-register reads |
| ctrl_a | output | 5 | Control A fields |
| ctrl_b | output | 5 | Control B fields |
| volt_sel | output | 2 | Output voltage range and step select |
| out_enable | output | 1 | Supply output enable |

## Verification
The bench builds the block with the default 200 MHz clock and 50 ns spike limit, which give an 11-cycle line filter. It runs SCL with an 80-cycle half period, well above the filter delay, so each bus phase is exercised with margin. The injected spikes last exactly 10 cycles (50 ns). They therefore sit one cycle below the filter limit, and a filter that is one cycle short fails the spike test.

// File: rtl/pwr_i2c_pkg.sv
package pwr_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_RNXT
  } bus_st_t;

  localparam logic [2:0] SEL_STAT = 3'b000;
  localparam logic [2:0] SEL_CTLA = 3'b001;
  localparam logic [2:0] SEL_CTLB = 3'b010;
  localparam logic [2:0] SEL_OUT  = 3'b011;
  localparam logic [4:0] ADDR_BASE = 5'b00010;
endpackage

// File: rtl/pwr_i2c_deglitch.sv
module pwr_i2c_deglitch #(
  parameter int WIDTH    = 2,
  parameter int FILT_LEN = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] line_i,
  output logic [WIDTH-1:0] line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic s1, s2, q, q_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
      q_n   = q;
      cnt_n = '0;
      if (s2 != q) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          q_n = s2;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1  <= 1'b1;
        s2  <= 1'b1;
        q   <= 1'b1;
        cnt <= '0;
      end else begin
        s1  <= line_i[g];
        s2  <= s1;
        q   <= q_n;
        cnt <= cnt_n;
      end
    end

    assign line_o[g] = q;

    // R10: the filtered level moves only after the input has stood still long enough
    a_r10_filtered_move: assert property (@(posedge clk) disable iff (!rst_n)
      (q != q_n) |-> (cnt == CW'(FILT_LEN - 1)));
  end
endmodule

// File: rtl/pwr_i2c_bus_fsm.sv
module pwr_i2c_bus_fsm
  import pwr_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] addr_sel,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] rd_byte,
  output logic [1:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       sda_pull
);
  bus_st_t    st, st_n;
  logic [2:0] cnt, cnt_n;
  logic [7:0] sh, sh_n;
  logic       pull_n, rw, rw_n;
  logic [1:0] ptr, ptr_n;
  logic       scl_d, sda_d;
  logic       scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;
  assign wr_data  = {sh[6:0], sda_f};
  assign rd_idx   = ptr;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sh_n   = sh;
    pull_n = sda_pull;
    rw_n   = rw;
    ptr_n  = ptr;
    wr_en  = 1'b0;
    if (!pwr_good) begin
      st_n = ST_IDLE; pull_n = 1'b0; cnt_n = '0; ptr_n = '0;
    end else if (start_c) begin
      st_n = ST_ADDR; pull_n = 1'b0; cnt_n = '0; ptr_n = '0;
    end else if (stop_c) begin
      st_n = ST_IDLE; pull_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR: if (scl_rise) begin
          sh_n  = {sh[6:0], sda_f};
          cnt_n = cnt + 1'b1;
          if (cnt == 3'd7) begin
            rw_n = sda_f;
            st_n = (sh[6:0] == {ADDR_BASE, addr_sel}) ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!sda_pull) begin
            pull_n = 1'b1;
          end else begin
            cnt_n = '0;
            if (rw) begin
              st_n = ST_RD; sh_n = rd_byte; pull_n = ~rd_byte[7]; ptr_n = ptr + 1'b1;
            end else begin
              st_n = ST_WR; pull_n = 1'b0;
            end
          end
        end
        ST_WR: if (scl_rise) begin
          sh_n  = {sh[6:0], sda_f};
          cnt_n = cnt + 1'b1;
          if (cnt == 3'd7) begin
            wr_en = 1'b1;
            st_n  = ST_WACK;
          end
        end
        ST_WACK: if (scl_fall) begin
          if (!sda_pull) begin
            pull_n = 1'b1;
          end else begin
            pull_n = 1'b0; st_n = ST_WR; cnt_n = '0;
          end
        end
        ST_RD: if (scl_fall) begin
          cnt_n = cnt + 1'b1;
          sh_n  = {sh[6:0], 1'b0};
          if (cnt == 3'd7) begin
            pull_n = 1'b0; st_n = ST_RACK;
          end else begin
            pull_n = ~sh[6];
          end
        end
        ST_RACK: if (scl_rise) begin
          st_n = sda_f ? ST_IDLE : ST_RNXT;
        end
        ST_RNXT: if (scl_fall) begin
          st_n = ST_RD; sh_n = rd_byte; pull_n = ~rd_byte[7]; ptr_n = ptr + 1'b1; cnt_n = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_pull <= 1'b0;
      rw       <= 1'b0;
      ptr      <= '0;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      st       <= st_n;
      cnt      <= cnt_n;
      sh       <= sh_n;
      sda_pull <= pull_n;
      rw       <= rw_n;
      ptr      <= ptr_n;
      scl_d    <= scl_f;
      sda_d    <= sda_f;
    end
  end

  // R9: no drive on the bus while power is not good
  a_r9_quiet_when_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !sda_pull);
  // R8: a STOP always frees the line and idles the engine
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && stop_c && !start_c) |=> (!sda_pull && st == ST_IDLE));
  // R1: the line is only pulled while addressed
  a_r1_pull_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st != ST_IDLE && st != ST_ADDR));
  // R5: during a read byte the line carries the current MSB of the shifter
  a_r5_msb_on_line: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> (sda_pull == ~sh[7]));
endmodule

// File: rtl/pwr_i2c_regfile.sv
module pwr_i2c_regfile
  import pwr_i2c_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_idx,
  input  logic [4:0] fault_in,
  input  logic       tone_det,
  output logic [7:0] rd_byte,
  output logic [4:0] ctrl_a,
  output logic [4:0] ctrl_b,
  output logic [1:0] volt_sel,
  output logic       out_enable
);
  logic [4:0] a_n, b_n;
  logic [1:0] vs_n;
  logic       en_n;

  always_comb begin
    a_n  = ctrl_a;
    b_n  = ctrl_b;
    vs_n = volt_sel;
    en_n = out_enable;
    if (!pwr_good) begin
      a_n = '0; b_n = '0; vs_n = '0; en_n = 1'b0;
    end else if (wr_en) begin
      unique case (wr_data[7:5])
        SEL_CTLA: a_n = wr_data[4:0];
        SEL_CTLB: b_n = wr_data[4:0];
        SEL_OUT: begin
          en_n = wr_data[4];
          vs_n = wr_data[1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a     <= '0;
      ctrl_b     <= '0;
      volt_sel   <= '0;
      out_enable <= 1'b0;
    end else begin
      ctrl_a     <= a_n;
      ctrl_b     <= b_n;
      volt_sel   <= vs_n;
      out_enable <= en_n;
    end
  end

  always_comb begin
    unique case (rd_idx)
      2'd0: rd_byte = {SEL_STAT, fault_in};
      2'd1: rd_byte = {SEL_CTLA, ctrl_a};
      2'd2: rd_byte = {SEL_CTLB, ctrl_b};
      default: rd_byte = {SEL_OUT, out_enable, tone_det, 1'b0, volt_sel};
    endcase
  end

  // R9: everything cleared while power is not good
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (ctrl_a == '0 && ctrl_b == '0 && volt_sel == '0 && !out_enable));
  // R3: enable rises only as the result of a write
  a_r3_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_enable) |-> $past(wr_en && pwr_good));
  // R3: enable and voltage fields land in the same cycle
  a_r3_fields_together: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && wr_en && wr_data[7:5] == SEL_OUT) |=>
      (out_enable == $past(wr_data[4]) && volt_sel == $past(wr_data[1:0])));
  // R4: status-register and spare-code writes change nothing
  a_r4_ro_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && wr_en && (wr_data[7:5] == SEL_STAT || wr_data[7])) |=>
      ($stable(ctrl_a) && $stable(ctrl_b) && $stable(volt_sel) && $stable(out_enable)));
endmodule

// File: rtl/pwr_i2c_target.sv
module pwr_i2c_target #(
  parameter int CLK_MHZ   = 200,
  parameter int GLITCH_NS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic [1:0] addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  input  logic [4:0] fault_in,
  input  logic       tone_det,
  output logic [4:0] ctrl_a,
  output logic [4:0] ctrl_b,
  output logic [1:0] volt_sel,
  output logic       out_enable
);
  localparam int FILT_LEN = (GLITCH_NS * CLK_MHZ) / 1000 + 1;

  logic       rst_m, rst_s;
  logic [1:0] lines_f;
  logic       wr_en;
  logic [7:0] wr_data, rd_byte;
  logic [1:0] rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  pwr_i2c_deglitch #(.WIDTH(2), .FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_s), .line_i({scl_i, sda_i}), .line_o(lines_f)
  );

  pwr_i2c_bus_fsm u_fsm (
    .clk(clk), .rst_n(rst_s), .pwr_good(pwr_good), .addr_sel(addr_sel),
    .scl_f(lines_f[1]), .sda_f(lines_f[0]), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_data(wr_data), .sda_pull(sda_pull)
  );

  pwr_i2c_regfile u_regs (
    .clk(clk), .rst_n(rst_s), .pwr_good(pwr_good), .wr_en(wr_en), .wr_data(wr_data),
    .rd_idx(rd_idx), .fault_in(fault_in), .tone_det(tone_det), .rd_byte(rd_byte),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .volt_sel(volt_sel), .out_enable(out_enable)
  );
endmodule

// File: tb/tb_pwr_i2c_target.sv
`timescale 1ns/1ps
module tb_pwr_i2c_target;
  localparam int H  = 80;
  localparam int GL = 10;

  logic clk = 1'b0;
  logic rst_n, pwr_good, scl_m, sda_m, tone_det;
  logic [1:0] addr_sel;
  logic [4:0] fault_in, ctrl_a, ctrl_b;
  logic [1:0] volt_sel;
  logic out_enable, sda_pull, sda_bus;
  int checks = 0, errors = 0;
  logic [4:0] m_a = '0, m_b = '0;
  logic [1:0] m_vs = '0;
  logic m_en = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  pwr_i2c_target dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull), .fault_in(fault_in),
    .tone_det(tone_det), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .volt_sel(volt_sel),
    .out_enable(out_enable)
  );

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, {out_enable, volt_sel, ctrl_b, ctrl_a}, {m_en, m_vs, m_b, m_a});
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H); sda_m = 1'b0; wc(H); scl_m = 1'b0; wc(H/2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wc(H/2); scl_m = 1'b1; wc(H); sda_m = 1'b1; wc(H);
  endtask

  task automatic put_bit(input logic b, input logic gl_sda, input logic gl_scl);
    sda_m = b; wc(H/2);
    if (gl_scl) begin scl_m = 1'b1; wc(GL); scl_m = 1'b0; wc(H/4); end
    scl_m = 1'b1; wc(H/2);
    if (gl_sda) begin sda_m = ~b; wc(GL); sda_m = b; wc(H/2 - GL); end
    else wc(H/2);
    scl_m = 1'b0; wc(H/2);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wc(H/2); scl_m = 1'b1; wc(H/2); b = sda_bus; wc(H/2); scl_m = 1'b0; wc(H/2);
  endtask

  task automatic send_byte(input logic [7:0] d, input int gl_sda_bit, input int gl_scl_bit,
                           output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i], i == gl_sda_bit, i == gl_scl_bit);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(nack, 1'b0, 1'b0);
  endtask

  function automatic logic [7:0] aw(input logic [1:0] p, input logic rd);
    return {5'b00010, p, rd};
  endfunction

  // ---------- scenarios ----------
  task automatic t_reset();
    chk("R11 reset outputs", {out_enable, volt_sel, ctrl_b, ctrl_a}, 0);
    chk("R11 reset sda_pull", sda_pull, 0);
  endtask

  task automatic t_write_multi();
    logic ack;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack); chk("R1 address ack", ack, 1);
    send_byte(8'b001_10101, -1, -1, ack);   chk("R2 data ack ctrl_a", ack, 1);
    send_byte(8'b010_01011, -1, -1, ack);   chk("R2 data ack ctrl_b", ack, 1);
    i2c_stop();
    m_a = 5'b10101; m_b = 5'b01011;
    chk_regs("R2 R3 multi-byte write");
  endtask

  task automatic t_write_out();
    logic ack;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack);
    send_byte(8'b011_1_1_1_10, -1, -1, ack); chk("R2 output reg ack", ack, 1);
    i2c_stop();
    m_en = 1'b1; m_vs = 2'b10;
    chk_regs("R3 enable and voltage fields");
  endtask

  task automatic t_read_wrap();
    logic ack;
    logic [7:0] d;
    fault_in = 5'b10110; tone_det = 1'b1;
    i2c_start();
    send_byte(aw(2'b00, 1'b1), -1, -1, ack); chk("R1 read address ack", ack, 1);
    recv_byte(1'b0, d); chk("R5 R6 status byte", d, {3'b000, 5'b10110});
    recv_byte(1'b0, d); chk("R6 control A byte", d, {3'b001, m_a});
    recv_byte(1'b0, d); chk("R6 control B byte", d, {3'b010, m_b});
    recv_byte(1'b0, d); chk("R5 output byte with tone", d, {3'b011, m_en, 1'b1, 1'b0, m_vs});
    recv_byte(1'b1, d); chk("R6 wrap to status", d, {3'b000, 5'b10110});
    wc(H); chk("R7 released after nack", sda_pull, 0);
    i2c_stop();
  endtask

  task automatic t_readonly();
    logic ack;
    logic [7:0] d;
    tone_det = 1'b0; fault_in = 5'b01001;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack);
    send_byte(8'b000_11111, -1, -1, ack); chk("R2 status write acked", ack, 1);
    send_byte(8'b101_11111, -1, -1, ack);
    send_byte(8'b111_00000, -1, -1, ack);
    send_byte(8'b011_1_0_1_10, -1, -1, ack);
    i2c_stop();
    chk_regs("R4 read-only writes no effect");
    i2c_start();
    send_byte(aw(2'b00, 1'b1), -1, -1, ack);
    recv_byte(1'b0, d); chk("R4 status keeps live flags", d, {3'b000, 5'b01001});
    recv_byte(1'b0, d);
    recv_byte(1'b0, d);
    recv_byte(1'b1, d); chk("R4 output reg bits 3:2", d, {3'b011, m_en, 1'b0, 1'b0, m_vs});
    i2c_stop();
  endtask

  task automatic t_addr_pins();
    logic ack;
    i2c_start();
    send_byte(aw(2'b01, 1'b0), -1, -1, ack); chk("R1 wrong address nack", ack, 0);
    send_byte(8'b001_00000, -1, -1, ack);   chk("R1 data after miss nack", ack, 0);
    i2c_stop();
    chk_regs("R1 unmatched write ignored");
    addr_sel = 2'b11;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack); chk("R1 base address no match pins 11", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(aw(2'b11, 1'b0), -1, -1, ack); chk("R1 address 0x0B ack", ack, 1);
    send_byte(8'b001_00111, -1, -1, ack);
    i2c_stop();
    m_a = 5'b00111;
    chk_regs("R1 write via pin address");
    addr_sel = 2'b00;
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack);
    for (int i = 7; i >= 4; i--) put_bit(d[0], 1'b0, 1'b0);
    i2c_stop();
    chk_regs("R8 stop discards partial byte");
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack);
    put_bit(1'b0, 1'b0, 1'b0); put_bit(1'b0, 1'b0, 1'b0); put_bit(1'b1, 1'b0, 1'b0);
    i2c_start();
    send_byte(aw(2'b00, 1'b1), -1, -1, ack); chk("R8 restart address ack", ack, 1);
    recv_byte(1'b1, d); chk("R8 R6 restart reads status", d, {3'b000, fault_in});
    i2c_stop();
    chk_regs("R8 restart left registers");
  endtask

  task automatic t_glitch();
    logic ack;
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, 4, ack); chk("R10 scl spike in address", ack, 1);
    send_byte(8'b010_10110, 6, 2, ack);     chk("R10 spikes in data ack", ack, 1);
    i2c_stop();
    m_b = 5'b10110;
    chk_regs("R10 spikes rejected");
  endtask

  task automatic t_power();
    logic ack;
    pwr_good = 1'b0; wc(5);
    m_a = '0; m_b = '0; m_vs = '0; m_en = 1'b0;
    chk_regs("R9 cleared when power low");
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack); chk("R9 no ack when power low", ack, 0);
    send_byte(8'b011_1_0_0_11, -1, -1, ack);
    i2c_stop();
    chk_regs("R9 writes ignored when power low");
    pwr_good = 1'b1; wc(5);
    i2c_start();
    send_byte(aw(2'b00, 1'b0), -1, -1, ack); chk("R9 ack after power good", ack, 1);
    send_byte(8'b011_1_0_0_11, -1, -1, ack);
    i2c_stop();
    m_en = 1'b1; m_vs = 2'b11;
    chk_regs("R9 R3 write after power good");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pwr_good = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 2'b00; fault_in = '0; tone_det = 1'b0;
    wc(10); rst_n = 1'b1; wc(20);
    t_reset();
    t_write_multi();
    t_write_out();
    t_read_wrap();
    t_readonly();
    t_addr_pins();
    t_abort();
    t_glitch();
    t_power();
    finish_run();
  end
endmodule